// File: doc/BRIEF.md
# Pin-Multiplexed GPIO Port Controller

This block controls a port of general-purpose pins. Software reaches it through a simple word-wide register bus: a write strobe, a shared address, write data, and read data that follows the address in the same cycle. Every pin works in one of two modes. In software mode the pin's output enable comes from a direction register and its output value from a data register. In peripheral mode both are taken from one of four attached peripheral functions, and a packed two-bit field for each pin picks which one.

Direction and output data have no plain write address. Each has a set alias and a clear alias, and only the bits written as 1 change, so software can update one pin without a read-modify-write. An input-enable mask gates what the port sees from the pads. The peripherals receive the gated pad values, and software reads them through a pin-value register. When a pin's input is gated off, the pin-value register shows what the port itself drives on that pin. Interrupt detection is left to a separate block.

Top module: `gpio_pinmux_port`

## Requirements
- R1: After reset every pin is in software mode as an input (pad_oe all 0, pad_out all 0), with input enable 0, data 0 and all function selects 0. Reading any register returns 0.
- R2: Address 0 is the mode register, read/write with one bit per pin. A 0 selects software mode and a 1 selects peripheral mode.
- R3: Address 1 is the function select register, read/write over all 32 bits. Bits 2n+1:2n choose function f (0..3) for pin n. In peripheral mode pad_oe[n] = per_oe[f*16+n] and pad_out[n] = per_out[f*16+n].
- R4: In software mode pad_oe[n] equals direction bit n, where 1 means output, and pad_out[n] equals data bit n.
- R5: A write to address 2 sets the direction bits written as 1, and a write to address 3 clears the direction bits written as 1. Bits written as 0 are left as they are. A read of either address returns the direction register.
- R6: A write to address 4 sets the data bits written as 1, and a write to address 5 clears them. Other bits are unchanged. A read of either address returns the data register.
- R7: Address 6 is the input-enable register, read/write. A read of address 7 returns pad_in[n] for every pin whose input enable is 1.
- R8: For a pin whose input enable is 0, the read of address 7 returns pad_out[n] if pad_oe[n] is 1 and 0 otherwise.
- R9: periph_in[n] equals pad_in[n] when input enable n is 1, and 0 otherwise.
- R10: Addresses 8 to 15 read as 0, and writes to them change no register and no output.
- R11: Address 7 is read-only: a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, available in the same cycle |
| pad_in | input | 16 | Values seen at the pads |
| pad_out | output | 16 | Output value for each pad |
| pad_oe | output | 16 | Output enable for each pad |
| per_out | input | 64 | Peripheral outputs, function f for pin n at bit f*16+n |
| per_oe | input | 64 | Peripheral output enables, same layout as per_out |
| periph_in | output | 16 | Gated pad values sent to the peripherals |

## Verification
The bench builds the block with its default values: 16 pins, four functions, a 4-bit address and a 32-bit data word. With these values the function select register is filled exactly, so the field of the top pin sits at bits 31:30, and half of the address space is unmapped and can be probed. Random register writes, pad values and peripheral drives are mixed with directed cases: alias writes with some bits 0, the highest function on the top pin, and gated inputs on pins that drive. This reaches every mode, alias and gating combination the port has.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  localparam int REG_MODE   = 0;
  localparam int REG_FSEL   = 1;
  localparam int REG_DIRSET = 2;
  localparam int REG_DIRCLR = 3;
  localparam int REG_OUTSET = 4;
  localparam int REG_OUTCLR = 5;
  localparam int REG_INEN   = 6;
  localparam int REG_PINVAL = 7;
endpackage

// File: rtl/gpm_rst_sync.sv
module gpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpm_regfile.sv
module gpm_regfile
  import gpm_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int FSEL_W   = 2,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM_PINS-1:0]          pin_val,
  output logic [DATA_W-1:0]            rdata,
  output logic [NUM_PINS-1:0]          mode_q,
  output logic [NUM_PINS*FSEL_W-1:0]   fsel_q,
  output logic [NUM_PINS-1:0]          dir_q,
  output logic [NUM_PINS-1:0]          dat_q,
  output logic [NUM_PINS-1:0]          inen_q
);
  localparam int SEL_BITS = NUM_PINS * FSEL_W;

  logic [NUM_PINS-1:0] mode_d, dir_d, dat_d, inen_d;
  logic [SEL_BITS-1:0] fsel_d;
  logic                mode_en, fsel_en, dir_en, dat_en, inen_en;
  logic [NUM_PINS-1:0] wbits;

  assign wbits = wdata[NUM_PINS-1:0];

  always_comb begin
    mode_en = 1'b0; fsel_en = 1'b0; dir_en = 1'b0; dat_en = 1'b0; inen_en = 1'b0;
    mode_d  = mode_q; fsel_d = fsel_q; dir_d = dir_q; dat_d = dat_q; inen_d = inen_q;
    if (we) begin
      case (addr)
        ADDR_W'(REG_MODE):   begin mode_en = 1'b1; mode_d = wbits; end
        ADDR_W'(REG_FSEL):   begin fsel_en = 1'b1; fsel_d = wdata[SEL_BITS-1:0]; end
        ADDR_W'(REG_DIRSET): begin dir_en = 1'b1;  dir_d  = dir_q | wbits; end
        ADDR_W'(REG_DIRCLR): begin dir_en = 1'b1;  dir_d  = dir_q & ~wbits; end
        ADDR_W'(REG_OUTSET): begin dat_en = 1'b1;  dat_d  = dat_q | wbits; end
        ADDR_W'(REG_OUTCLR): begin dat_en = 1'b1;  dat_d  = dat_q & ~wbits; end
        ADDR_W'(REG_INEN):   begin inen_en = 1'b1; inen_d = wbits; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; fsel_q <= '0; dir_q <= '0; dat_q <= '0; inen_q <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (fsel_en) fsel_q <= fsel_d;
      if (dir_en)  dir_q  <= dir_d;
      if (dat_en)  dat_q  <= dat_d;
      if (inen_en) inen_q <= inen_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(REG_MODE):   rdata = DATA_W'(mode_q);
      ADDR_W'(REG_FSEL):   rdata = DATA_W'(fsel_q);
      ADDR_W'(REG_DIRSET),
      ADDR_W'(REG_DIRCLR): rdata = DATA_W'(dir_q);
      ADDR_W'(REG_OUTSET),
      ADDR_W'(REG_OUTCLR): rdata = DATA_W'(dat_q);
      ADDR_W'(REG_INEN):   rdata = DATA_W'(inen_q);
      ADDR_W'(REG_PINVAL): rdata = DATA_W'(pin_val);
      default:             rdata = '0;
    endcase
  end

  // R5
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(REG_DIRSET)) |=> (dir_q == ($past(dir_q) | $past(wdata[NUM_PINS-1:0]))));
  // R5
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(REG_DIRCLR)) |=> ((dir_q & $past(wdata[NUM_PINS-1:0])) == '0));
  // R6
  dat_clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(REG_OUTCLR)) |=> ((dat_q & ~$past(wdata[NUM_PINS-1:0])) == ($past(dat_q) & ~$past(wdata[NUM_PINS-1:0]))));
  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr > ADDR_W'(REG_PINVAL)) |=> ($stable(mode_q) && $stable(fsel_q) && $stable(dir_q) && $stable(dat_q) && $stable(inen_q)));
endmodule

// File: rtl/gpm_pad_mux.sv
module gpm_pad_mux #(
  parameter int NUM_PINS = 16,
  parameter int NUM_FUNC = 4,
  parameter int FSEL_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         mode_q,
  input  logic [NUM_PINS*FSEL_W-1:0]  fsel_q,
  input  logic [NUM_PINS-1:0]         dir_q,
  input  logic [NUM_PINS-1:0]         dat_q,
  input  logic [NUM_FUNC*NUM_PINS-1:0] per_out,
  input  logic [NUM_FUNC*NUM_PINS-1:0] per_oe,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_oe
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic [NUM_FUNC-1:0] fn_out, fn_oe;
    logic [FSEL_W-1:0]   sel;
    assign sel = fsel_q[n*FSEL_W +: FSEL_W];
    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
      assign fn_out[f] = per_out[f*NUM_PINS + n];
      assign fn_oe[f]  = per_oe[f*NUM_PINS + n];
    end
    assign pad_out[n] = mode_q[n] ? fn_out[sel] : dat_q[n];
    assign pad_oe[n]  = mode_q[n] ? fn_oe[sel]  : dir_q[n];
  end

  // R4
  sw_mode_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ dir_q) & ~mode_q) == '0) && (((pad_out ^ dat_q) & ~mode_q) == '0));
endmodule

// File: rtl/gpm_in_gate.sv
module gpm_in_gate #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] inen_q,
  input  logic [NUM_PINS-1:0] pad_out,
  input  logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pin_val,
  output logic [NUM_PINS-1:0] periph_in
);
  always_comb begin
    periph_in = pad_in & inen_q;
    pin_val   = periph_in | (~inen_q & pad_oe & pad_out);
  end

  // R8
  gated_idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_val & ~inen_q & ~pad_oe) == '0);
  // R9
  gated_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_in & ~pad_in) == '0);
endmodule

// File: rtl/gpio_pinmux_port.sv
module gpio_pinmux_port #(
  parameter int NUM_PINS = 16,
  parameter int NUM_FUNC = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [NUM_PINS-1:0]          pad_in,
  output logic [NUM_PINS-1:0]          pad_out,
  output logic [NUM_PINS-1:0]          pad_oe,
  input  logic [NUM_FUNC*NUM_PINS-1:0] per_out,
  input  logic [NUM_FUNC*NUM_PINS-1:0] per_oe,
  output logic [NUM_PINS-1:0]          periph_in
);
  localparam int FSEL_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1;

  logic                       rst_n_sync;
  logic [NUM_PINS-1:0]        mode_q, dir_q, dat_q, inen_q, pin_val;
  logic [NUM_PINS*FSEL_W-1:0] fsel_q;

  gpm_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  gpm_regfile #(.NUM_PINS(NUM_PINS), .FSEL_W(FSEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n_sync), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pin_val(pin_val), .rdata(bus_rdata), .mode_q(mode_q), .fsel_q(fsel_q),
    .dir_q(dir_q), .dat_q(dat_q), .inen_q(inen_q)
  );

  gpm_pad_mux #(.NUM_PINS(NUM_PINS), .NUM_FUNC(NUM_FUNC), .FSEL_W(FSEL_W)) i_mux (
    .clk(clk), .rst_n(rst_n_sync), .mode_q(mode_q), .fsel_q(fsel_q), .dir_q(dir_q),
    .dat_q(dat_q), .per_out(per_out), .per_oe(per_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpm_in_gate #(.NUM_PINS(NUM_PINS)) i_gate (
    .clk(clk), .rst_n(rst_n_sync), .pad_in(pad_in), .inen_q(inen_q), .pad_out(pad_out),
    .pad_oe(pad_oe), .pin_val(pin_val), .periph_in(periph_in)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n_sync |-> (pad_oe == '0 && mode_q == '0 && inen_q == '0));
endmodule

// File: tb/test_gpio_pinmux_port.sv
module test_gpio_pinmux_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] pad_in, pad_out, pad_oe, periph_in;
  logic [63:0] per_out, per_oe;

  logic [15:0] m_mode, m_dir, m_dat, m_inen;
  logic [31:0] m_fsel;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_pinmux_port i_gpio_pinmux_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .per_out(per_out), .per_oe(per_oe), .periph_in(periph_in)
  );

  function automatic logic [15:0] exp_oe();
    logic [15:0] r;
    for (int n = 0; n < 16; n++)
      r[n] = m_mode[n] ? per_oe[m_fsel[2*n +: 2]*16 + n] : m_dir[n];
    return r;
  endfunction

  function automatic logic [15:0] exp_out();
    logic [15:0] r;
    for (int n = 0; n < 16; n++)
      r[n] = m_mode[n] ? per_out[m_fsel[2*n +: 2]*16 + n] : m_dat[n];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return {16'h0, m_mode};
      4'd1: return m_fsel;
      4'd2, 4'd3: return {16'h0, m_dir};
      4'd4, 4'd5: return {16'h0, m_dat};
      4'd6: return {16'h0, m_inen};
      4'd7: return {16'h0, (pad_in & m_inen) | (~m_inen & exp_oe() & exp_out())};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      4'd0: m_mode = d[15:0];
      4'd1: m_fsel = d;
      4'd2: m_dir  = m_dir | d[15:0];
      4'd3: m_dir  = m_dir & ~d[15:0];
      4'd4: m_dat  = m_dat | d[15:0];
      4'd5: m_dat  = m_dat & ~d[15:0];
      4'd6: m_inen = d[15:0];
      default: ;
    endcase
  endtask

  task automatic rd_check(input string req, input logic [3:0] a);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp_read(a));
  endtask

  task automatic pads_check(input string req);
    #1;
    check({req, " pad_oe"}, {16'h0, pad_oe}, {16'h0, exp_oe()});
    check({req, " pad_out"}, {16'h0, pad_out}, {16'h0, exp_out()});
    check("R9 periph_in", {16'h0, periph_in}, {16'h0, pad_in & m_inen});
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 16; a++) rd_check(req, 4'(a));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = 16'hA5C3; per_out = '0; per_oe = '0;
    m_mode = '0; m_dir = '0; m_dat = '0; m_inen = '0; m_fsel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    pads_check("R1");
    read_all("R1 reset read");

    // R5 set alias with some zero bits, then clear alias
    wr(4'd2, 32'h0000_F00F); rd_check("R5 dirset read", 4'd2);
    wr(4'd3, 32'h0000_300C); rd_check("R5 dirclr read", 4'd3);
    wr(4'd2, 32'h0000_0000); rd_check("R5 zero write keeps", 4'd2);
    // R6
    wr(4'd4, 32'h0000_0FF1); rd_check("R6 outset read", 4'd4);
    wr(4'd5, 32'h0000_0F00); rd_check("R6 outclr read", 4'd5);
    pads_check("R4");
    // R8 gated pins that drive show pad_out
    rd_check("R8 pinval gated", 4'd7);
    // R7
    wr(4'd6, 32'h0000_FFFF); rd_check("R7 pinval enabled", 4'd7);
    pads_check("R7");
    // R11 read-only pin value
    wr(4'd7, 32'hFFFF_FFFF); read_all("R11 pinval readonly");
    // R10 unmapped writes
    wr(4'd9, 32'hFFFF_FFFF); wr(4'd15, 32'h1234_5678);
    read_all("R10 unmapped"); pads_check("R10");

    // R3 top pin highest function
    per_out = 64'h8000_0000_0000_0000; per_oe = 64'h8000_0000_0000_0000;
    wr(4'd1, 32'hC000_0000); wr(4'd0, 32'h0000_8000);
    rd_check("R2 mode read", 4'd0); rd_check("R3 fsel read", 4'd1);
    pads_check("R3 top pin");
    check("R3 top pin oe", {31'h0, pad_oe[15]}, 32'h1);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      a = 4'($urandom_range(0, 15));
      d = $urandom();
      pad_in  = 16'($urandom());
      per_out = {$urandom(), $urandom()};
      per_oe  = {$urandom(), $urandom()};
      wr(a, d);
      pads_check("R2 R3 R4 random");
      rd_check("R5 R6 R7 R8 random read", 4'($urandom_range(0, 15)));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule